// File: doc/BRIEF.md
# Rotate-and-Mask Operand Field Extractor

This stage prepares the A operand of an 8-bit ALU. It accepts a source byte together with a right-rotate amount and a field length. It rotates the byte end-around to the right so that the lowest bit of the wanted bit string arrives at bit 0. It then clears every bit above the chosen field width. As a result, any contiguous bit field of the source, including one that wraps past bit 7, comes out right-justified and zero-extended. When an operation moves data between two internal registers, a mode input turns the mask off. Only the rotate acts in that mode, and all eight bits pass through.

The stage uses a valid/ready stream on both sides and holds one registered result. An input beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Its result is presented on the following cycle with `out_valid` high. `in_ready` is high when the output register is empty or when the downstream side takes the current result in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the stage stalls. During a stall the result and `out_valid` hold still, and no new beat is taken. `out_data` keeps its last value whenever no beat is accepted.

Top module: `rme_field_extract`

## Requirements
- R1: A synchronous active-high reset leaves `out_valid` at 0 and `out_data` at 8'h00 after the next clock edge.
- R2: For a rotate amount r from 1 to 7, the rotated byte has bit i equal to source bit (i+r) mod 8. Bits that leave bit 0 wrap around and re-enter at bit 7.
- R3: A rotate amount of 0 leaves the source byte unrotated.
- R4: In field mode (`in_reg_mode`=0), a length code L from 1 to 7 keeps bits [L-1:0] of the rotated byte and forces bits [7:L] to 0.
- R5: In field mode, length code 0 selects an 8-bit field, so the whole rotated byte passes through.
- R6: In register mode (`in_reg_mode`=1), the length code has no effect and all 8 rotated bits are output.
- R7: An accepted beat sets `out_valid` on the next clock edge, and `out_data` then carries that beat's result.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1, `out_data` is stable, `in_ready` is 0, and an offered input is not taken.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`. If no beat is accepted, `out_data` keeps its previous value and `out_valid` falls once the result has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Stage can take a beat this cycle |
| in_data | input | 8 | Source byte |
| in_rot | input | 3 | Right-rotate amount, 0 to 7 |
| in_len | input | 3 | Field length code, 1 to 7 bits, 0 meaning 8 bits |
| in_reg_mode | input | 1 | 1 = register-to-register operation, mask bypassed |
| out_valid | output | 1 | Result register holds a beat |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 8 | Prepared ALU A operand |

## Verification
A wrong rotate stage or mask stage shows up as a bad `out_data` exactly one cycle after the faulty beat is accepted. Sweeping every rotate amount against every length code in both modes makes each bit-select path visible at least once. A broken occupancy flag shows up within one cycle, as `out_valid` or `in_ready` disagreeing with the handshake history. It can also show up as a result that is lost or repeated while `out_ready` is held low. The bench compares all three outputs on every cycle, so any such fault is caught on the cycle it first appears.

// File: rtl/rme_pkg.sv
package rme_pkg;
  typedef enum logic {
    MODE_FIELD = 1'b0,
    MODE_REG   = 1'b1
  } rme_mode_e;
endpackage

// File: rtl/rme_rotate.sv
module rme_rotate #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [CNT_W-1:0]  amount,
  output logic [DATA_W-1:0] dst
);
  logic [DATA_W-1:0] stage [0:CNT_W];

  assign stage[0] = src;

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    logic [DATA_W-1:0] turned;
    assign turned = {stage[s][STEP-1:0], stage[s][DATA_W-1:STEP]};
    assign stage[s+1] = amount[s] ? turned : stage[s];
  end

  assign dst = stage[CNT_W];
endmodule

// File: rtl/rme_mask.sv
module rme_mask #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  len_code,
  input  logic              bypass,
  output logic [DATA_W-1:0] dout
);
  logic full_width;
  assign full_width = bypass || (len_code == '0);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic keep;
    assign keep    = full_width || (CNT_W'(i) < len_code);
    assign dout[i] = din[i] & keep;
  end
endmodule

// File: rtl/rme_field_extract.sv
module rme_field_extract #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_rot,
  input  logic [CNT_W-1:0]  in_len,
  input  logic              in_reg_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  import rme_pkg::*;

  rme_mode_e         mode;
  logic [DATA_W-1:0] rotated;
  logic [DATA_W-1:0] masked;
  logic              accept;
  logic              occ_q;
  logic [DATA_W-1:0] res_q;

  assign mode = rme_mode_e'(in_reg_mode);

  rme_rotate #(.DATA_W(DATA_W)) u_rot (
    .src    (in_data),
    .amount (in_rot),
    .dst    (rotated)
  );

  rme_mask #(.DATA_W(DATA_W)) u_mask (
    .din      (rotated),
    .len_code (in_len),
    .bypass   (mode == MODE_REG),
    .dout     (masked)
  );

  assign in_ready = !occ_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= 1'b0;
      res_q <= '0;
    end else begin
      if (accept) begin
        occ_q <= 1'b1;
        res_q <= masked;
      end else if (out_ready) begin
        occ_q <= 1'b0;
      end
    end
  end

  assign out_valid = occ_q;
  assign out_data  = res_q;

  // R7: a taken beat is presented next cycle
  p_accept_shows_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R8: stalled result holds
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9: no accept, no change of data
  p_idle_keep_r9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(out_data));

  // R4: bits above a short field come out clear
  p_field_clear_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !in_reg_mode && (in_len != '0)
    |=> (out_data >> $past(in_len)) == '0);

  // R1: reset empties the output
  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> !out_valid && (out_data == '0));
endmodule

// File: tb/rme_field_extract_bench.sv
module rme_field_extract_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic [2:0] in_rot;
  logic [2:0] in_len;
  logic       in_reg_mode;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string tag = "R1";

  logic       exp_v;
  logic [7:0] exp_d;

  always #10 clk = ~clk;

  rme_field_extract u_rme_field_extract (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_rot(in_rot), .in_len(in_len), .in_reg_mode(in_reg_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [7:0] ref_result(input int src, input int r,
                                            input int len, input bit regm);
    int rot;
    int width;
    rot   = ((src >> r) | (src << (8 - r))) & 255;
    width = (regm || len == 0) ? 8 : len;
    return 8'(rot & ((1 << width) - 1));
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      exp_v <= 1'b0;
      exp_d <= 8'h00;
    end else if (in_valid && (!exp_v || out_ready)) begin
      exp_v <= 1'b1;
      exp_d <= ref_result(int'(in_data), int'(in_rot), int'(in_len), in_reg_mode);
    end else if (out_ready) begin
      exp_v <= 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && cycles > 0) begin
      check("R9", int'(in_ready), int'(!exp_v || out_ready), "in_ready");
      check(tag == "R8" ? "R8" : "R7", int'(out_valid), int'(exp_v), "out_valid");
      check(tag, int'(out_data), int'(exp_d), "out_data");
    end
  end

  task automatic drive(input logic v, input logic [7:0] d, input int r,
                       input int l, input logic m, input logic rdy);
    @(negedge clk);
    #1;
    in_valid    = v;
    in_data     = d;
    in_rot      = 3'(r);
    in_len      = 3'(l);
    in_reg_mode = m;
    out_ready   = rdy;
  endtask

  initial begin
    rst = 1'b1; in_valid = 0; in_data = 0; in_rot = 0; in_len = 0;
    in_reg_mode = 0; out_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(out_valid), 0, "out_valid after reset");
    check("R1", int'(out_data), 0, "out_data after reset");
    rst = 1'b0;

    // R2 R3 R4 R5 field mode, then R6 register mode
    for (int m = 0; m < 2; m++) begin
      tag = (m == 0) ? "R2 R3 R4 R5" : "R6";
      for (int r = 0; r < 8; r++)
        for (int l = 0; l < 8; l++)
          drive(1'b1, 8'((r * 37 + l * 91 + m * 13) ^ 8'hA5), r, l, m[0], 1'b1);
    end

    // R3 rotate zero on a distinct pattern, R5 full length
    tag = "R3 R5";
    drive(1'b1, 8'h81, 0, 0, 1'b0, 1'b1);
    drive(1'b1, 8'h3C, 0, 0, 1'b0, 1'b1);

    // R8 back-pressure with changing offered input
    tag = "R8";
    drive(1'b1, 8'hF0, 4, 3, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++)
      drive(1'b1, 8'(k * 29 + 5), k, k, 1'b0, 1'b0);
    drive(1'b1, 8'h96, 5, 6, 1'b1, 1'b1);

    // R9 idle gaps: data holds, valid drains
    tag = "R9";
    for (int k = 0; k < 4; k++)
      drive(1'b0, 8'hFF, 7, 1, 1'b0, 1'b1);
    drive(1'b1, 8'h5A, 1, 4, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 0, 0, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 0, 0, 1'b0, 1'b1);
    drive(1'b0, 8'h00, 0, 0, 1'b0, 1'b1);

    // R1 mid-run reset
    tag = "R1";
    drive(1'b1, 8'h77, 2, 0, 1'b0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R1", int'(out_valid), 0, "out_valid after second reset");
    check("R1", int'(out_data), 0, "out_data after second reset");
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule